// File: doc/BRIEF.md
# Linear Ramp Envelope Engine with Arrival Event Queue

This block runs a large bank of linear ramps through one shared arithmetic unit. Each ramp has four words the host can write and read back: the present value, a target, a signed step and a two-bit control field. A prescaler produces an update tick, nominally 4 kHz. At each tick, if the global run input is high, a sequencer visits every ramp once, one ramp per clock. Each active ramp either adds its step to its present value or, when that step would land on or cross the target, takes the target exactly. After that it holds the target until the host rewrites it. Every visited ramp presents its new value on a time-multiplexed output bus tagged with its index. Downstream oscillators pick up their frequency or amplitude from that bus.

A ramp whose interrupt-enable bit is set records its arrival by pushing its index into a small event queue, exactly once per arrival. The interrupt line stays high while the queue holds anything. The host reads the head index at one place and pops it. If the queue is full, further arrivals are dropped and a sticky overflow flag is raised.

The sequencer has two named states. SEQ_IDLE waits; the transition SEQ_IDLE to SEQ_SWEEP fires on a prescaler tick while run is high. SEQ_SWEEP visits one ramp index per clock; the transition SEQ_SWEEP to SEQ_IDLE fires after the last index. A tick that comes while run is low is skipped, so all ramps stop and resume together on tick boundaries.

Top module: `ramp_engine`

## Requirements
- R1: After reset all ramp words read as zero, out_valid, irq, evt_valid and evt_ovf are low, and no sweep starts until run is high at a tick.
- R2: Each sweep emits exactly NUM_RAMPS consecutive out_valid cycles with out_idx counting 0, 1, ... NUM_RAMPS-1.
- R3: For an active ramp (control bit 0 = 1) whose step does not reach the target, out_value and the stored present value become present + step (signed, 24-bit).
- R4: The step direction is taken from the sign of the step, with zero counted as upward. If present + step reaches or passes the target in that direction, the value becomes exactly the target and stays there on later sweeps. This holds with no wrap-around for any signed 24-bit present, target and step values, extremes included.
- R5: A ramp with control bit 0 = 0 keeps its present value. It is still emitted on out_value unchanged, and it never produces an event.
- R6: A ramp with control bit 1 = 1 pushes its index once when it first arrives. irq is high exactly while the queue is not empty. evt_idx shows the oldest index, and a pulse on evt_pop removes it, in arrival order.
- R7: A host write to the present, target or step word (select codes 0, 1, 2) re-arms the ramp, so its next arrival queues a new event.
- R8: An arrival found with the queue full (EVT_DEPTH entries) is dropped, and evt_ovf goes high and stays high until reset.
- R9: While run is low, no sweep begins and out_valid stays low.
- R10: h_rdata returns the word chosen by h_idx and h_sel (0 present, 1 target, 2 step, 3 control in bits 1:0). The present word reflects sweep updates.
- R11: An arriving ramp with control bit 1 = 0 pushes no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Global run enable, sampled at each tick |
| h_we | input | 1 | Host write strobe |
| h_idx | input | IDX_W | Host ramp index |
| h_sel | input | 2 | Word select: 0 present, 1 target, 2 step, 3 control |
| h_wdata | input | VAL_W | Host write data |
| h_rdata | output | VAL_W | Host read data (combinational) |
| out_valid | output | 1 | Ramp value output valid |
| out_idx | output | IDX_W | Index of the emitted ramp |
| out_value | output | VAL_W | Updated ramp value (signed) |
| irq | output | 1 | High while the event queue is non-empty |
| evt_valid | output | 1 | Head entry present |
| evt_idx | output | IDX_W | Index at the queue head |
| evt_pop | input | 1 | Removes the head entry |
| evt_ovf | output | 1 | Sticky queue overflow flag |

## Verification
The assertions rely on two conditions. TICK_DIV is larger than NUM_RAMPS, so a tick never lands inside a sweep. The host does not pop and overflow the queue in the same cycle. The bench meets both: it uses a 4-ramp, 40-cycle-tick configuration, and it writes or pops only after dropping run, once the current sweep has ended. That also keeps host writes from colliding with the ramp being updated. The step data sweep covers upward, downward, zero-step, already-passed and full-scale ramps.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

    localparam int VAL_W = 24;

    typedef enum logic [0:0] {
        SEQ_IDLE  = 1'b0,
        SEQ_SWEEP = 1'b1
    } seq_state_t;

    localparam logic [1:0] WSEL_CUR = 2'd0;
    localparam logic [1:0] WSEL_FIN = 2'd1;
    localparam logic [1:0] WSEL_INC = 2'd2;
    localparam logic [1:0] WSEL_CTL = 2'd3;

    localparam int CTL_ACT_BIT = 0;
    localparam int CTL_IRQ_BIT = 1;

endpackage

// File: rtl/ramp_step.sv
module ramp_step #(
    parameter int W = 24
) (
    input  logic signed [W-1:0] cur,
    input  logic signed [W-1:0] fin,
    input  logic signed [W-1:0] inc,
    output logic signed [W-1:0] nxt,
    output logic                reach
);
    // one guard bit keeps gap and sum free of wrap-around
    logic signed [W:0] gap;
    logic signed [W:0] inc_x;
    logic signed [W:0] sum;

    always_comb begin
        gap   = {fin[W-1], fin} - {cur[W-1], cur};
        inc_x = {inc[W-1], inc};
        sum   = {cur[W-1], cur} + inc_x;
        if (inc[W-1]) begin
            reach = (inc_x <= gap);
        end else begin
            reach = (inc_x >= gap);
        end
        nxt = reach ? fin : sum[W-1:0];
    end
endmodule

// File: rtl/ramp_seq.sv
module ramp_seq
    import ramp_pkg::*;
#(
    parameter int NUM      = 128,
    parameter int TICK_DIV = 25000,
    localparam int IDX_W   = $clog2(NUM),
    localparam int CNT_W   = $clog2(TICK_DIV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic             proc,
    output logic [IDX_W-1:0] proc_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM - 1);
    localparam logic [CNT_W-1:0] TICK_TOP = CNT_W'(TICK_DIV - 1);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] pcnt_q;
    logic             tick;

    assign tick = (pcnt_q == TICK_TOP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (tick) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + CNT_W'(1);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SEQ_SWEEP && idx_q != LAST_IDX) begin
                idx_q <= idx_q + IDX_W'(1);
            end else begin
                idx_q <= '0;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (tick && run)        state_d = SEQ_SWEEP;
            SEQ_SWEEP: if (idx_q == LAST_IDX)  state_d = SEQ_IDLE;
            default:                           state_d = SEQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        proc     = (state_q == SEQ_SWEEP);
        proc_idx = idx_q;
    end

    // R2
    sweep_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_SWEEP && idx_q != LAST_IDX) |=>
        (state_q == SEQ_SWEEP && idx_q == $past(idx_q) + IDX_W'(1)));

    // R9
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE && !run) |=> (state_q == SEQ_IDLE));
endmodule

// File: rtl/ramp_evt_fifo.sv
module ramp_evt_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 7,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          valid,
    output logic [DW-1:0] head,
    output logic          ovf
);
    localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic          ovf_q;
    logic          full, acc_push, do_pop;

    assign full     = (cnt_q == FULL_CNT);
    assign acc_push = push && !full;
    assign do_pop   = pop && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (acc_push) begin
                mem_q[wp_q] <= push_data;
                wp_q <= (wp_q == LAST_PTR) ? '0 : wp_q + AW'(1);
            end
            if (do_pop) begin
                rp_q <= (rp_q == LAST_PTR) ? '0 : rp_q + AW'(1);
            end
            cnt_q <= cnt_q + (AW+1)'(acc_push) - (AW+1)'(do_pop);
            if (push && full) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign valid = (cnt_q != '0);
    assign head  = mem_q[rp_q];
    assign ovf   = ovf_q;

    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (cnt_q == $past(cnt_q)));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);
endmodule

// File: rtl/ramp_engine.sv
module ramp_engine
    import ramp_pkg::*;
#(
    parameter int NUM_RAMPS = 128,
    parameter int TICK_DIV  = 25000,
    parameter int EVT_DEPTH = 16,
    parameter int W         = VAL_W,
    localparam int IDX_W    = $clog2(NUM_RAMPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             h_we,
    input  logic [IDX_W-1:0] h_idx,
    input  logic [1:0]       h_sel,
    input  logic [W-1:0]     h_wdata,
    output logic [W-1:0]     h_rdata,
    output logic             out_valid,
    output logic [IDX_W-1:0] out_idx,
    output logic [W-1:0]     out_value,
    output logic             irq,
    output logic             evt_valid,
    output logic [IDX_W-1:0] evt_idx,
    input  logic             evt_pop,
    output logic             evt_ovf
);
    logic signed [W-1:0] cur_q [NUM_RAMPS];
    logic signed [W-1:0] fin_q [NUM_RAMPS];
    logic signed [W-1:0] inc_q [NUM_RAMPS];
    logic [1:0]          ctl_q [NUM_RAMPS];
    logic                arr_q [NUM_RAMPS];

    logic                proc;
    logic [IDX_W-1:0]    p_idx;
    logic signed [W-1:0] cur_s, fin_s, inc_s, nxt;
    logic                reach, active, host_hit, do_upd, new_arr, push;

    ramp_seq #(.NUM(NUM_RAMPS), .TICK_DIV(TICK_DIV)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run),
        .proc(proc), .proc_idx(p_idx)
    );

    always_comb begin
        cur_s = cur_q[p_idx];
        fin_s = fin_q[p_idx];
        inc_s = inc_q[p_idx];
    end

    ramp_step #(.W(W)) u_step (
        .cur(cur_s), .fin(fin_s), .inc(inc_s), .nxt(nxt), .reach(reach)
    );

    // a host write to the ramp under update wins; the engine skips it
    assign active   = ctl_q[p_idx][CTL_ACT_BIT];
    assign host_hit = h_we && (h_idx == p_idx);
    assign do_upd   = proc && active && !host_hit;
    assign new_arr  = do_upd && reach && !arr_q[p_idx];
    assign push     = new_arr && ctl_q[p_idx][CTL_IRQ_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_RAMPS; i++) begin
                cur_q[i] <= '0;
                fin_q[i] <= '0;
                inc_q[i] <= '0;
                ctl_q[i] <= '0;
                arr_q[i] <= 1'b0;
            end
            out_valid <= 1'b0;
            out_idx   <= '0;
            out_value <= '0;
        end else begin
            if (do_upd) begin
                cur_q[p_idx] <= nxt;
                if (reach) arr_q[p_idx] <= 1'b1;
            end
            if (h_we) begin
                unique case (h_sel)
                    WSEL_CUR: begin cur_q[h_idx] <= h_wdata; arr_q[h_idx] <= 1'b0; end
                    WSEL_FIN: begin fin_q[h_idx] <= h_wdata; arr_q[h_idx] <= 1'b0; end
                    WSEL_INC: begin inc_q[h_idx] <= h_wdata; arr_q[h_idx] <= 1'b0; end
                    WSEL_CTL: ctl_q[h_idx] <= h_wdata[1:0];
                    default:  ;
                endcase
            end
            out_valid <= proc;
            out_idx   <= p_idx;
            out_value <= do_upd ? nxt : cur_s;
        end
    end

    always_comb begin
        unique case (h_sel)
            WSEL_CUR: h_rdata = cur_q[h_idx];
            WSEL_FIN: h_rdata = fin_q[h_idx];
            WSEL_INC: h_rdata = inc_q[h_idx];
            WSEL_CTL: h_rdata = {{(W-2){1'b0}}, ctl_q[h_idx]};
            default:  h_rdata = '0;
        endcase
    end

    ramp_evt_fifo #(.DEPTH(EVT_DEPTH), .DW(IDX_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_data(p_idx), .pop(evt_pop),
        .valid(evt_valid), .head(evt_idx), .ovf(evt_ovf)
    );

    assign irq = evt_valid;

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_upd |-> ((nxt >= cur_s && nxt <= fin_s) || (nxt <= cur_s && nxt >= fin_s)));

    // R5
    idle_ramp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc && !active && !host_hit) |=> (out_value == $past(cur_s)));
endmodule

// File: tb/ramp_engine_tb.sv
module ramp_engine_tb;
    localparam int N   = 4;
    localparam int TD  = 40;
    localparam int DEP = 4;
    localparam int W   = 24;
    localparam int IW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          h_we = 1'b0;
    logic [IW-1:0] h_idx = '0;
    logic [1:0]    h_sel = '0;
    logic [W-1:0]  h_wdata = '0;
    logic [W-1:0]  h_rdata;
    logic          out_valid;
    logic [IW-1:0] out_idx;
    logic [W-1:0]  out_value;
    logic          irq, evt_valid, evt_ovf;
    logic [IW-1:0] evt_idx;
    logic          evt_pop = 1'b0;

    int nchk = 0;
    int nerr = 0;

    longint m_cur [N];
    longint m_fin [N];
    longint m_inc [N];
    int     m_ctl [N];
    bit     m_arr [N];
    bit     m_ovf = 1'b0;
    int     q [$];

    always #5 clk = ~clk;

    ramp_engine #(.NUM_RAMPS(N), .TICK_DIV(TD), .EVT_DEPTH(DEP), .W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .run(run),
        .h_we(h_we), .h_idx(h_idx), .h_sel(h_sel), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .out_valid(out_valid), .out_idx(out_idx), .out_value(out_value),
        .irq(irq), .evt_valid(evt_valid), .evt_idx(evt_idx), .evt_pop(evt_pop), .evt_ovf(evt_ovf)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int i, input int s, input longint v);
        @(negedge clk);
        h_we = 1'b1; h_idx = IW'(i); h_sel = 2'(s); h_wdata = v[W-1:0];
        @(negedge clk);
        h_we = 1'b0;
        case (s)
            0: begin m_cur[i] = v; m_arr[i] = 1'b0; end
            1: begin m_fin[i] = v; m_arr[i] = 1'b0; end
            2: begin m_inc[i] = v; m_arr[i] = 1'b0; end
            default: m_ctl[i] = int'(v);
        endcase
    endtask

    task automatic setup(input int i, input longint c, input longint f, input longint s, input int ctl);
        wr(i, 0, c); wr(i, 1, f); wr(i, 2, s); wr(i, 3, ctl);
    endtask

    task automatic rd_chk(input int i, input int s, input longint exp, input string req);
        longint act;
        @(negedge clk);
        h_idx = IW'(i); h_sel = 2'(s);
        #1;
        act = (s == 3) ? longint'(h_rdata) : longint'($signed(h_rdata));
        chk(act == exp, req, act, exp);
    endtask

    task automatic check_out();
        int k;
        longint v, c, f, s, nx;
        bit reach;
        k = int'(out_idx);
        v = longint'($signed(out_value));
        if (m_ctl[k][0] == 1'b0) begin
            chk(v == m_cur[k], "R5", v, m_cur[k]);
        end else begin
            c = m_cur[k]; f = m_fin[k]; s = m_inc[k];
            reach = (s >= 0) ? (c + s >= f) : (c + s <= f);
            nx = reach ? f : c + s;
            chk(v == nx, reach ? "R4" : "R3", v, nx);
            if (reach && !m_arr[k]) begin
                m_arr[k] = 1'b1;
                if (m_ctl[k][1]) begin
                    if (q.size() < DEP) q.push_back(k);
                    else m_ovf = 1'b1;
                end
            end
            m_cur[k] = nx;
        end
    endtask

    task automatic run_sweeps(input int k);
        int seen = 0;
        int guard = 0;
        int expi = 0;
        @(negedge clk);
        run = 1'b1;
        while (seen < k * N && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (out_valid) begin
                chk(int'(out_idx) == expi, "R2", out_idx, expi);
                check_out();
                expi = (expi + 1) % N;
                seen++;
            end
        end
        run = 1'b0;
        chk(seen == k * N, "R2", seen, k * N);
    endtask

    task automatic drain();
        while (q.size() > 0) begin
            @(negedge clk);
            chk(evt_valid && irq && int'(evt_idx) == q[0], "R6", evt_idx, q[0]);
            evt_pop = 1'b1;
            @(negedge clk);
            evt_pop = 1'b0;
            void'(q.pop_front());
        end
        @(negedge clk);
        chk(!evt_valid && !irq, "R6 R11", evt_valid, 0);
        chk(evt_ovf == m_ovf, "R8", evt_ovf, m_ovf);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
        $finish;
    end

    initial begin
        int quiet;
        for (int i = 0; i < N; i++) begin
            m_cur[i] = 0; m_fin[i] = 0; m_inc[i] = 0; m_ctl[i] = 0; m_arr[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!out_valid && !irq && !evt_valid && !evt_ovf, "R1", out_valid, 0);
        for (int s = 0; s < 4; s++) rd_chk(1, s, 0, "R1");
        quiet = 0;
        repeat (2 * TD) begin @(negedge clk); if (out_valid) quiet++; end
        chk(quiet == 0, "R1", quiet, 0);

        // round A: up, down, inactive, no-interrupt ramp
        setup(0, 0, 100, 30, 3);
        setup(1, 100, -50, -40, 3);
        setup(2, 7, 50, 1, 0);
        setup(3, 0, 10, 4, 1);
        run_sweeps(5);

        // R9 stopped engine stays silent
        quiet = 0;
        repeat (3 * TD) begin @(negedge clk); if (out_valid) quiet++; end
        chk(quiet == 0, "R9", quiet, 0);

        // R10 readback after updates
        rd_chk(0, 0, 100, "R10");
        rd_chk(1, 0, -50, "R10");
        rd_chk(2, 0, 7, "R10");
        rd_chk(3, 3, 1, "R10");
        rd_chk(1, 2, -40, "R10");
        // R11 ramp 3 arrived without an event: only 0 and 1 queued
        chk(q.size() == 2, "R11", q.size(), 2);
        drain();

        // round B: extremes, zero step, already past
        setup(0, -8388608, 8388607, 8388607, 3);
        setup(1, 8388607, -8388608, -8388608, 3);
        setup(2, 5, 5, 0, 3);
        setup(3, 20, 10, 5, 3);
        run_sweeps(3);
        drain();

        // round C: R7 rewrite present word of ramp 0 re-arms it
        wr(0, 0, 0);
        run_sweeps(2);
        @(negedge clk);
        chk(evt_valid && evt_idx == 2'd0 && q.size() == 1, "R7", evt_idx, 0);
        drain();

        // round D: R8 fill queue then overflow
        for (int i = 0; i < N; i++) setup(i, i * 3, i * 3, 1, 3);
        run_sweeps(1);
        wr(0, 0, -4);
        wr(1, 2, 9);
        run_sweeps(1);
        @(negedge clk);
        chk(evt_ovf == 1'b1 && m_ovf, "R8", evt_ovf, 1);
        drain();

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule